// File: doc/BRIEF.md
# Frame-Period Refill Interrupt Timer

This block paces the refilling of a frame buffer that feeds a continuous pixel output stream. It counts cycles of the output pixel clock and, once per frame time, raises an interrupt request toward the bus bridge. Each request asks the host to move exactly one frame into the buffer. Because the period equals the time the output side needs to drain one frame, the buffer's fill level stays level over the long run.

The timer is held off until an arm input goes high. Control logic raises arm only after one whole frame has been written into the buffer ahead of the output. This keeps the buffer one frame ahead of the reader at all times. Dropping arm stops the timer and withdraws any outstanding request.

The request is an active-low level. It stays low until the host acknowledges it or until a short timeout runs out. A sticky flag records any period that ended while the previous request was still outstanding. A wrapping counter tallies the requests issued.

Top module: `frame_refill_timer`

## Requirements
- R1: After reset, irq_n is 1, overrun is 0 and irq_count is 0.
- R2: While arm is sampled 0 at a clock edge, irq_n is 1 after that edge and the period count restarts from zero. No request is raised while arm stays low.
- R3: irq_n falls exactly PERIOD rising edges after the first edge at which arm is sampled 1. While arm stays 1, later requests are issued every PERIOD edges.
- R4: irq_ack sampled 1 while a request is pending returns irq_n to 1 after that edge, unless a new period expires at the same edge.
- R5: An unacknowledged request keeps irq_n at 0 for exactly TIMEOUT cycles and then releases it, provided no new period expires in that time.
- R6: irq_count rises by exactly one for each request issued. It is CNT_W bits wide and wraps from all ones to zero, and only reset clears it.
- R7: overrun becomes 1 when a period expires while a request is still pending. Once set, it stays 1 until reset, whatever the state of arm.
- R8: irq_ack pulsed while no request is pending has no effect: irq_n stays 1 and the next request arrives on its scheduled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output pixel clock; all counting uses it |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Timer enable, raised after one frame is preloaded |
| irq_ack | input | 1 | Host acknowledge pulse for the pending request |
| irq_n | output | 1 | Active-low interrupt request level |
| overrun | output | 1 | Sticky flag: a period ended while a request was pending |
| irq_count | output | CNT_W | Wrapping count of requests issued |

## Verification
The assertions assume that arm and irq_ack are synchronous to clk and settle between edges. They also assume that PERIOD is at least 2 and TIMEOUT at least 1. The bench drives every input on the falling edge, so each value is stable at the rising edge that samples it.

The random phase draws acknowledge pulses at any time, including when no request is pending, and drops arm briefly and rarely. With the long-period instance, the timeout always ends before the next period, so overrun must never appear there. A second, short-period instance is driven only with directed stimulus to force the overrun case.

// File: rtl/frt_pkg.sv
// Shared types for the frame refill timer.
package frt_pkg;
    // Request handshake state: idle, or waiting for acknowledge or timeout.
    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_WAIT = 1'b1
    } req_state_t;
endpackage

// File: rtl/frt_period.sv
// Period counter: counts output clocks while armed and pulses expire on the
// last count of each period. Assumes PERIOD >= 2. Disarming clears the count.
module frt_period #(
    parameter int PERIOD = 131200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expire
);
    localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt;

    // Terminal count reached while armed.
    assign expire = arm && (cnt == LAST);

    // Advance the count; restart on disarm or at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (!arm)   cnt <= '0;
        else if (expire) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/frt_request.sv
// Request holder: a pending request is raised on expire and dropped by an
// acknowledge, by the timeout or by disarming. Also keeps the sticky overrun
// flag. Assumes TIMEOUT >= 1.
module frt_request
    import frt_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic expire,
    input  logic ack,
    output logic pending,
    output logic overrun
);
    localparam int AW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [AW-1:0] AGE_LAST = AW'(TIMEOUT - 1);

    req_state_t      state;
    logic [AW-1:0]   age;
    logic            timeout;

    // The request has stayed up for its full timeout window.
    assign timeout = (state == REQ_WAIT) && (age == AGE_LAST);
    assign pending = (state == REQ_WAIT);

    // Request state: an expire wins over an acknowledge or a timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   state <= REQ_IDLE;
        else if (!arm)                                state <= REQ_IDLE;
        else if (expire)                              state <= REQ_WAIT;
        else if (state == REQ_WAIT && (ack || timeout)) state <= REQ_IDLE;
    end

    // Age of the current request; restarts on each new request.
    always_ff @(posedge clk) begin
        if (!rst_n)                 age <= '0;
        else if (!arm || expire)    age <= '0;
        else if (state == REQ_WAIT) age <= age + 1'b1;
        else                        age <= '0;
    end

    // Sticky overrun: a period ended with a request still outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)                          overrun <= 1'b0;
        else if (expire && state == REQ_WAIT) overrun <= 1'b1;
    end
endmodule

// File: rtl/frt_counter.sv
// Wrapping event counter: adds one on each bump, and only reset clears it.
module frt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    // Count the issued requests, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (bump) count <= count + 1'b1;
    end
endmodule

// File: rtl/frame_refill_timer.sv
// Top of the frame refill interrupt timer. clk is the output pixel clock. A
// request is issued each PERIOD clocks while arm is high, with the first one
// coming one full period after arm rises. irq_n is the active-low request level.
module frame_refill_timer #(
    parameter int PERIOD  = 131200,
    parameter int TIMEOUT = 16,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             irq_ack,
    output logic             irq_n,
    output logic             overrun,
    output logic [CNT_W-1:0] irq_count
);
    logic expire;
    logic pending;

    frt_period #(.PERIOD(PERIOD)) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .expire (expire)
    );

    frt_request #(.TIMEOUT(TIMEOUT)) u_request (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .expire  (expire),
        .ack     (irq_ack),
        .pending (pending),
        .overrun (overrun)
    );

    frt_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (expire),
        .count (irq_count)
    );

    // Drive the request line low while a request is pending.
    assign irq_n = ~pending;
endmodule

// File: rtl/frt_checker.sv
// Protocol checker for frame_refill_timer, attached with bind.
module frt_checker #(
    parameter int TIMEOUT = 16,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             irq_ack,
    input logic             irq_n,
    input logic             overrun,
    input logic [CNT_W-1:0] irq_count,
    input logic             expire
);
    localparam int RW = $clog2(TIMEOUT + 2) + 1;
    logic [RW-1:0] run_q;

    // Count the cycles of the current low request, restarting on each new one.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (expire)     run_q <= RW'(1);
        else if (!irq_n && run_q != {RW{1'b1}}) run_q <= run_q + 1'b1;
        else if (irq_n)      run_q <= '0;
    end

    p_arm_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> irq_n);

    p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_n && !expire) |=> irq_n);

    p_timeout_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (run_q <= RW'(TIMEOUT)));

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_count != $past(irq_count)) |-> (irq_count == $past(irq_count) + 1'b1));

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind frame_refill_timer frt_checker #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .irq_ack   (irq_ack),
    .irq_n     (irq_n),
    .overrun   (overrun),
    .irq_count (irq_count),
    .expire    (expire)
);

// File: tb/tb_frame_refill_timer.sv
module tb_frame_refill_timer;
    localparam int P  = 40;
    localparam int TO = 16;
    localparam int CW = 4;
    localparam int P2 = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0, ack = 1'b0, arm2 = 1'b0;
    logic irq_n, ovr, irq_n2, ovr2;
    logic [CW-1:0] cnt, cnt2;

    int checks = 0, fails = 0, cycles = 0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    frame_refill_timer #(.PERIOD(P), .TIMEOUT(TO), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .irq_ack(ack),
        .irq_n(irq_n), .overrun(ovr), .irq_count(cnt));

    frame_refill_timer #(.PERIOD(P2), .TIMEOUT(TO), .CNT_W(CW)) dut_ov (
        .clk(clk), .rst_n(rst_n), .arm(arm2), .irq_ack(1'b0),
        .irq_n(irq_n2), .overrun(ovr2), .irq_count(cnt2));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model of the requirements, stepped on each rising edge.
    int m_cnt = 0, m_age = 0;
    bit m_pend = 0, m_ovr = 0;
    logic [CW-1:0] m_count = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_age = 0; m_pend = 0; m_ovr = 0; m_count = '0;
        end else if (!arm) begin
            m_cnt = 0; m_age = 0; m_pend = 0;
        end else if (m_cnt == P - 1) begin
            if (m_pend) m_ovr = 1;
            m_pend = 1; m_age = 0; m_cnt = 0; m_count = m_count + 1'b1;
        end else begin
            m_cnt++;
            if (m_pend) begin
                if (ack || m_age == TO - 1) begin m_pend = 0; m_age = 0; end
                else m_age++;
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (model_on) begin
            chk(irq_n == !m_pend, "R3 irq_n vs model", int'(irq_n), int'(!m_pend));
            chk(ovr == m_ovr, "R7 overrun vs model", int'(ovr), int'(m_ovr));
            chk(cnt == m_count, "R6 irq_count vs model", int'(cnt), int'(m_count));
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count edges until irq_n falls; returns the edge count.
    task automatic wait_low(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (irq_n && n < 1000);
    endtask

    initial begin
        int n;
        void'($urandom(32'h5eed));
        tick(3);
        chk(irq_n && !ovr && cnt == 0, "R1 reset state", int'({irq_n, ovr, cnt}), 32);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R2: disarmed, nothing happens.
        tick(2 * P + 5);
        chk(irq_n == 1'b1, "R2 no request while disarmed", int'(irq_n), 1);
        chk(cnt == 0, "R2 no count while disarmed", int'(cnt), 0);

        // R3: first request one full period after arming.
        arm = 1'b1;
        wait_low(n);
        chk(n == P, "R3 first request delay", n, P);

        // R5: no acknowledge, released after TO cycles.
        n = 0;
        while (!irq_n && n < 200) begin @(negedge clk); n++; end
        chk(n == TO, "R5 timeout width", n, TO);

        // R8: acknowledge while idle is ignored; next request on schedule.
        ack = 1'b1; tick(1); ack = 1'b0;
        chk(irq_n == 1'b1, "R8 idle ack keeps irq_n high", int'(irq_n), 1);
        wait_low(n);
        chk(n == P - TO - 1, "R8 schedule kept after idle ack", n, P - TO - 1);
        chk(cnt == 2, "R6 count after two requests", int'(cnt), 2);

        // R4: acknowledge releases on the next edge.
        tick(2);
        ack = 1'b1; tick(1); ack = 1'b0;
        chk(irq_n == 1'b1, "R4 ack releases request", int'(irq_n), 1);

        // R2: dropping arm withdraws a pending request and restarts the period.
        wait_low(n);
        arm = 1'b0; tick(1);
        chk(irq_n == 1'b1, "R2 disarm clears request", int'(irq_n), 1);
        tick(3);
        arm = 1'b1;
        wait_low(n);
        chk(n == P, "R2 period restarts after disarm", n, P);

        // Random phase: acknowledge pulses and rare disarm drops.
        for (int i = 0; i < 4000; i++) begin
            ack = ($urandom % 8) == 0;
            if (($urandom % 300) == 0) arm = 1'b0;
            else if (!arm && ($urandom % 4) == 0) arm = 1'b1;
            tick(1);
        end
        ack = 1'b0;
        chk(ovr == 1'b0, "R7 no overrun when timeout beats period", int'(ovr), 0);

        // R7: short period instance, no acknowledge -> overrun.
        arm2 = 1'b1;
        tick(P2);
        chk(irq_n2 == 1'b0 && ovr2 == 1'b0, "R7 first request, no overrun yet",
            int'({irq_n2, ovr2}), 0);
        tick(P2);
        chk(ovr2 == 1'b1, "R7 overrun on expire while pending", int'(ovr2), 1);
        chk(cnt2 == 2, "R6 count with overrun", int'(cnt2), 2);
        arm2 = 1'b0; tick(5);
        chk(ovr2 == 1'b1 && irq_n2 == 1'b1, "R7 overrun sticky after disarm",
            int'({ovr2, irq_n2}), 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule